// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is a single output cell of a small programmable logic device. The block takes these inputs:

- a group of product-term results from the AND array;
- a per-cell output-enable term;
- two terms shared by all cells: an asynchronous clear and a synchronous set.

The cell ORs its logic terms into one sum. It then does one of two things with that sum:

- **Registered mode:** the sum is captured in a D flip-flop on the rising clock edge.
- **Combinatorial mode:** the sum is passed straight through.

The selected value goes through a programmable polarity stage and drives a tri-state pin model. That model is a value, an enable, and the resolved level seen on the wire.

A feedback signal goes back to the array in true and complement form. Its source depends on the mode:

- **Registered mode:** the feedback comes from the flip-flop's inverted output, so a registered pin is output-only.
- **Combinatorial mode:** the feedback is the resolved pin level. When the enable is off, an external driver can use the pin as an input.

The clear and set terms act on the flip-flop itself, before polarity is applied. After a clear, the pin therefore reads low with true polarity and high with inverted polarity. The number of logic terms is a parameter, because cells at different positions in the array receive different counts (8 or 10).

Top module: `macro_out_cell`

## Requirements
- R1: `cfg_i[0]`=1 selects true polarity and 0 selects inverted polarity. `cfg_i[1]`=1 selects combinatorial mode and 0 selects registered mode.
- R2: In registered mode, `pin_val_o` equals the flip-flop state through the selected polarity. The flip-flop loads the OR of all logic terms on each rising clock edge when neither clear nor set is active.
- R3: In combinatorial mode, `pin_val_o` equals the OR of the logic terms through the selected polarity, in the same cycle with no clock.
- R4: `pin_oe_o` follows `oe_term_i` in both modes. When the enable is low, `pin_level_o` equals `pin_ext_i`; otherwise it equals `pin_val_o`.
- R5: While `clr_term_i` is high, the flip-flop is zero at once, without waiting for a clock. With inverted polarity in registered mode, the pin then reads 1.
- R6: A high `set_term_i` with `clr_term_i` low makes the flip-flop one at the next rising clock edge.
- R7: When clear and set are both high, clear wins and the flip-flop stays zero.
- R8: In registered mode, `fb_true_o` is the inverse of the flip-flop state and `fb_comp_o` is the state itself. Pin enable and the external pin value have no effect on either output.
- R9: In combinatorial mode, `fb_true_o` equals `pin_level_o` and `fb_comp_o` is its inverse, so an external value reaches the feedback while the enable is low.
- R10: Each one of the `TERMS` logic inputs, alone, makes the sum one.
- R11: While `rst_ni` is low, the flip-flop is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Power-on reset, active low, clears the flip-flop |
| terms_i | input | TERMS | Logic product-term results |
| oe_term_i | input | 1 | Output-enable product term |
| clr_term_i | input | 1 | Shared asynchronous clear term |
| set_term_i | input | 1 | Shared synchronous set term |
| cfg_i | input | 2 | Bit 0 true polarity, bit 1 combinatorial mode |
| pin_ext_i | input | 1 | Value driven onto the pin from outside |
| pin_val_o | output | 1 | Value the cell drives onto the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| pin_level_o | output | 1 | Resolved level on the pin |
| fb_true_o | output | 1 | Feedback to the array, true form |
| fb_comp_o | output | 1 | Feedback to the array, complement form |

## Verification
The assertions check several rules on every clock cycle:

- clear forcing the flip-flop to zero, and clear winning over set;
- set taking effect one edge later;
- the pin falling back to the external value when the enable is off;
- the mode-dependent source of the feedback and of the combinatorial pin value.

Only the bench's scenarios can show the remaining behaviours:

- that clear acts in the middle of a cycle without a clock;
- that the captured register value appears one edge after the terms change;
- that the power-on state is correct;
- that every term position reaches the sum.

// File: rtl/macro_cell_pkg.sv
package macro_cell_pkg;

    typedef struct packed {
        logic pol_true;
        logic comb_mode;
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } cell_state_t;

    function automatic cell_cfg_t decode_cfg(input logic [1:0] raw);
        cell_cfg_t c;
        c.pol_true  = raw[0];
        c.comb_mode = raw[1];
        return c;
    endfunction

endpackage

// File: rtl/term_sum.sv
module term_sum #(
    parameter int TERMS = 8
) (
    input  logic [TERMS-1:0] terms_i,
    output logic             sum_o
);
    logic [TERMS:0] chain;

    assign chain[0] = 1'b0;

    for (genvar g = 0; g < TERMS; g++) begin : g_or
        assign chain[g+1] = chain[g] | terms_i[g];
    end

    assign sum_o = chain[TERMS];
endmodule

// File: rtl/cell_flop.sv
module cell_flop
    import macro_cell_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic set_i,
    input  logic d_i,
    output logic q_o
);
    cell_state_t state_d, state_q;
    logic        clear;

    assign clear = clr_i | ~rst_ni;

    always_comb begin
        state_d = state_q;
        if (set_i) begin
            state_d.q = 1'b1;
        end else begin
            state_d.q = d_i;
        end
    end

    always_ff @(posedge clk_i or posedge clear) begin
        if (clear) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.q;

    AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |-> !q_o)
        else $error("clear term did not hold flop at zero"); // R5

    AST_SET_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && !clr_i) |=> (q_o || clr_i))
        else $error("set term did not load one"); // R6

    AST_CLEAR_OVER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && clr_i) |-> !q_o)
        else $error("set beat clear"); // R7
endmodule

// File: rtl/cell_outsel.sv
module cell_outsel
    import macro_cell_pkg::*;
(
    input  cell_cfg_t cfg_i,
    input  logic      sum_i,
    input  logic      q_i,
    input  logic      oe_i,
    input  logic      ext_i,
    output logic      val_o,
    output logic      oe_o,
    output logic      level_o,
    output logic      fb_true_o,
    output logic      fb_comp_o
);
    logic pre_pol;
    logic fb_src;

    always_comb begin
        pre_pol   = cfg_i.comb_mode ? sum_i : q_i;
        val_o     = cfg_i.pol_true ? pre_pol : ~pre_pol;
        oe_o      = oe_i;
        level_o   = oe_i ? val_o : ext_i;
        fb_src    = cfg_i.comb_mode ? level_o : ~q_i;
        fb_true_o = fb_src;
        fb_comp_o = ~fb_src;
    end
endmodule

// File: rtl/macro_out_cell.sv
module macro_out_cell
    import macro_cell_pkg::*;
#(
    parameter int TERMS = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [TERMS-1:0] terms_i,
    input  logic             oe_term_i,
    input  logic             clr_term_i,
    input  logic             set_term_i,
    input  logic [1:0]       cfg_i,
    input  logic             pin_ext_i,
    output logic             pin_val_o,
    output logic             pin_oe_o,
    output logic             pin_level_o,
    output logic             fb_true_o,
    output logic             fb_comp_o
);
    cell_cfg_t cfg;
    logic      sum;
    logic      q;

    assign cfg = decode_cfg(cfg_i);

    term_sum #(.TERMS(TERMS)) u_sum (
        .terms_i (terms_i),
        .sum_o   (sum)
    );

    cell_flop u_flop (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_term_i),
        .set_i  (set_term_i),
        .d_i    (sum),
        .q_o    (q)
    );

    cell_outsel u_out (
        .cfg_i     (cfg),
        .sum_i     (sum),
        .q_i       (q),
        .oe_i      (oe_term_i),
        .ext_i     (pin_ext_i),
        .val_o     (pin_val_o),
        .oe_o      (pin_oe_o),
        .level_o   (pin_level_o),
        .fb_true_o (fb_true_o),
        .fb_comp_o (fb_comp_o)
    );

    AST_COMB_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_i[1] |-> (pin_val_o == ((|terms_i) ~^ cfg_i[0])))
        else $error("combinatorial pin value wrong"); // R3

    AST_PIN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_term_i |-> (pin_level_o == pin_ext_i))
        else $error("released pin not at external level"); // R4

    AST_REG_FEEDBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_i[1] && cfg_i[0]) |-> (fb_comp_o == pin_val_o))
        else $error("registered feedback not from flop"); // R8

    AST_COMB_FEEDBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_i[1] |-> (fb_true_o == pin_level_o && fb_comp_o != pin_level_o))
        else $error("combinatorial feedback not from pin"); // R9
endmodule

// File: tb/macro_out_cell_tb.sv
module macro_out_cell_tb;
    localparam int TERMS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TERMS-1:0] terms = '0;
    logic             oe = 1'b0, clr = 1'b0, set = 1'b0, ext = 1'b0;
    logic [1:0]       cfg = 2'b00;
    logic             pv, poe, plv, fbt, fbc;

    int  checks = 0, fails = 0;
    bit  done = 0;
    logic q_m = 1'b0;

    always #4 clk = ~clk;

    macro_out_cell #(.TERMS(TERMS)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .terms_i(terms), .oe_term_i(oe),
        .clr_term_i(clr), .set_term_i(set), .cfg_i(cfg), .pin_ext_i(ext),
        .pin_val_o(pv), .pin_oe_o(poe), .pin_level_o(plv),
        .fb_true_o(fbt), .fb_comp_o(fbc)
    );

    function automatic logic e_val(logic [1:0] c, logic s, logic qq);
        return (c[1] ? s : qq) ^ ~c[0];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic s, v, lv, fs;
        s  = |terms;
        v  = e_val(cfg, s, q_m);
        lv = oe ? v : ext;
        fs = cfg[1] ? lv : ~q_m;
        chk(cfg[1] ? "R3 comb value" : "R2 reg value", pv, v);
        chk("R4 enable", poe, oe);
        chk("R4 level", plv, lv);
        chk(cfg[1] ? "R9 fb true" : "R8 fb true", fbt, fs);
        chk(cfg[1] ? "R9 fb comp" : "R8 fb comp", fbc, ~fs);
    endtask

    task automatic tick();
        @(posedge clk);
        if (clr) q_m = 1'b0;
        else if (set) q_m = 1'b1;
        else q_m = |terms;
        #1;
        check_all();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        // R11: flop zero during reset; inverted polarity shows 1
        repeat (2) @(negedge clk);
        cfg = 2'b00; oe = 1'b1; terms = '1;
        @(posedge clk); #1;
        chk("R11 reset pin", pv, 1'b1);
        chk("R11 reset fb", fbt, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        terms = '0;
        tick();

        // R1: encoding with sum=1, flop loaded with 1
        terms = 10'b1; cfg = 2'b00; tick();
        chk("R1 reg inverted", pv, 1'b0);
        cfg = 2'b01; #1 chk("R1 reg true", pv, 1'b1);
        terms = '0;
        cfg = 2'b11; #1 chk("R1 comb true", pv, 1'b0);
        cfg = 2'b10; #1 chk("R1 comb inverted", pv, 1'b1);

        // R10: each term alone
        for (int i = 0; i < TERMS; i++) begin
            cfg = 2'b11; terms = '0; terms[i] = 1'b1;
            #1 chk("R10 single term", pv, 1'b1);
        end
        terms = '0;
        @(negedge clk);

        // R6: set to one at next edge with sum zero
        cfg = 2'b01; set = 1'b1; #1;
        chk("R6 before edge", pv, q_m);
        tick();
        chk("R6 after edge", pv, 1'b1);
        set = 1'b0;

        // R5: clear mid-cycle without a clock
        cfg = 2'b00; #2;
        chk("R5 pre clear", pv, 1'b0);
        clr = 1'b1; q_m = 1'b0; #1;
        chk("R5 async clear inverted pin", pv, 1'b1);
        chk("R5 async clear fb", fbt, 1'b1);
        // R7: clear wins over set
        set = 1'b1; terms = '1;
        tick();
        chk("R7 clear over set", pv, 1'b1);
        clr = 1'b0; set = 1'b0;

        // R8: registered fb unaffected by enable / external value
        terms = '1; cfg = 2'b01; tick();
        oe = 1'b0; ext = 1'b0; #1 chk("R8 fb ignores pin", fbt, 1'b0);
        ext = 1'b1; #1 chk("R8 fb ignores ext", fbc, 1'b1);
        // R9: comb feedback sees external drive
        cfg = 2'b11; terms = '0; ext = 1'b1; #1 chk("R9 ext to fb", fbt, 1'b1);
        ext = 1'b0; #1 chk("R9 ext low to fb", fbt, 1'b0);
        @(negedge clk);

        // random mix
        for (int n = 0; n < 400; n++) begin
            cfg   = 2'($urandom);
            terms = (($urandom % 3) == 0) ? TERMS'($urandom) : '0;
            if (($urandom % 4) == 0) terms[$urandom % TERMS] = 1'b1;
            oe    = 1'($urandom);
            ext   = 1'($urandom);
            set   = (($urandom % 6) == 0);
            clr   = (($urandom % 8) == 0);
            if (clr) q_m = 1'b0;
            #1;
            check_all();
            tick();
        end
        clr = 1'b0; set = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule